// File: doc/BRIEF.md
# Isolated Edge-Command Gate PWM with Local-to-Remote Handoff

This block produces the on/off command for the primary-side power switch of an isolated converter. Right after reset, an internal free-running oscillator drives the switch. Its on-time is limited by a soft-start limit word and by a fixed duty ceiling of about 72 % of the oscillator period. The secondary-side controller sends its switching edges across the isolation barrier. They arrive here as two digitized comparator flags: a start pulse marks a turn-on and a stop pulse marks a turn-off. Each pulse is accepted only if its length falls inside a configurable window of clock cycles.

The first accepted stop pulse clears the gate and locks the block to the remote controller. From then on only accepted start pulses turn the gate on, and stop pulses turn it off. The duty ceiling and the soft-start limit still cut off any pulse that runs too long. A pulse-by-pulse overcurrent flag ends the current pulse. A fault request forces the gate off, drops the lock and returns control to the local oscillator. The oscillator restarts from the beginning of its period whenever a cycle is started, so remote edges at a slightly higher frequency always arrive before the local cycle would end.

Top module: `pwm_handoff`

## Requirements
- R1: While `rst_n` is low `gateOn` is 0; after reset is released the gate first turns on `PERIOD_CYC` clock cycles later (sampled on the 100th falling clock edge after release with defaults, and still 0 on the 99th).
- R2: Before lock the gate repeats every `PERIOD_CYC` cycles and stays on for min(`ssLimit`, `MAX_ON`) cycles, where `MAX_ON` = `PERIOD_CYC`*`DUTY_PCT`/100 (72 with defaults).
- R3: With `ssLimit` = 0 the gate never turns on.
- R4: A start or stop pulse counts only if its synchronized high time is at least `MIN_W` and at most `MAX_W` clock cycles (6 and 50 by default). A shorter or longer pulse has no effect on the gate or on the lock.
- R5: A start pulse that arrives before lock is ignored.
- R6: The first accepted stop pulse clears the gate and sets the lock. After that the local oscillator no longer turns the gate on.
- R7: While locked, an accepted start pulse sets the gate and an accepted stop pulse clears it. The gate changes on the third rising clock edge after the input pulse falls.
- R8: While locked, a gate pulse with no stop pulse is cut off after min(`ssLimit`, `MAX_ON`) cycles, counted from the accepted start.
- R9: `ocFlag` high at a clock edge leaves the gate low after that edge, also when a set request occurs at the same edge. It does not change the lock.
- R10: `faultReq` high at a clock edge clears the gate and the lock and restarts the oscillator. After release the gate turns on under local control `PERIOD_CYC` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startEdge | input | 1 | Asynchronous remote turn-on pulse flag |
| stopEdge | input | 1 | Asynchronous remote turn-off pulse flag |
| ocFlag | input | 1 | Pulse-by-pulse overcurrent flag, clock-synchronous |
| faultReq | input | 1 | Fault request that restarts soft-start control, clock-synchronous |
| ssLimit | input | PHASE_W (7) | Soft-start on-time limit in clock cycles |
| gateOn | output | 1 | Gate-drive enable for the power switch |

## Verification
A lock bit stuck low shows up within one oscillator period: the gate keeps rising on the local schedule after a valid stop. A lock bit stuck high shows up as a missing turn-on `PERIOD_CYC` cycles after reset or after a fault. A wrong pulse-width window is visible three cycles after the edge of a pulse at the window boundary, because the gate fails to move or moves when it should not. A phase counter that miscounts changes the measured on-time or the cycle of the first rise, so it shows up within a single period.

// File: rtl/pwmho_pkg.sv
package pwmho_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRestart;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic startOk;
    logic stopOk;
    logic wrap;
    logic onDone;
    logic limitZero;
  } dpStatus_t;

endpackage

// File: rtl/pwmho_edge_qual.sv
module pwmho_edge_qual #(
  parameter int MIN_W = 6,
  parameter int MAX_W = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulseIn,
  output logic pulseOk
);
  localparam int LEN_W = $clog2(MAX_W + 2);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_W + 1);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_W);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_W);

  logic [1:0]       syncQ;
  logic             prevQ;
  logic [LEN_W-1:0] hiLen;
  logic             fallSeen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= 1'b0;
      hiLen <= '0;
    end else begin
      syncQ <= {syncQ[0], pulseIn};
      prevQ <= syncQ[1];
      if (syncQ[1]) begin
        if (hiLen != LEN_SAT) hiLen <= hiLen + 1'b1;
      end else begin
        hiLen <= '0;
      end
    end
  end

  // width is known once the synchronized pulse ends
  assign fallSeen = prevQ & ~syncQ[1];
  assign pulseOk  = fallSeen && (hiLen >= LEN_MIN) && (hiLen <= LEN_MAX);

endmodule

// File: rtl/pwmho_datapath.sv
module pwmho_datapath
  import pwmho_pkg::*;
#(
  parameter int PERIOD_CYC = 100,
  parameter int DUTY_PCT   = 72,
  parameter int MIN_W      = 6,
  parameter int MAX_W      = 50,
  localparam int PHASE_W   = $clog2(PERIOD_CYC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startIn,
  input  logic               stopIn,
  input  logic [PHASE_W-1:0] ssLimit,
  input  ctlStrobe_t         ctl,
  output dpStatus_t          stat
);
  localparam int MAX_ON = PERIOD_CYC * DUTY_PCT / 100;
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(PERIOD_CYC - 1);
  localparam logic [PHASE_W-1:0] ON_CAP     = PHASE_W'(MAX_ON);

  logic [1:0]         chanIn;
  logic [1:0]         chanOk;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] onLimit;

  assign chanIn = {stopIn, startIn};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    pwmho_edge_qual #(
      .MIN_W(MIN_W),
      .MAX_W(MAX_W)
    ) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .pulseIn(chanIn[ch]),
      .pulseOk(chanOk[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (ctl.cntRestart || phase == PHASE_LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    onLimit = (ssLimit > ON_CAP) ? ON_CAP : ssLimit;
    stat.startOk   = chanOk[0];
    stat.stopOk    = chanOk[1];
    stat.wrap      = (phase == PHASE_LAST);
    stat.limitZero = (onLimit == '0);
    stat.onDone    = (phase >= onLimit - 1'b1);
  end

endmodule

// File: rtl/pwmho_control.sv
module pwmho_control
  import pwmho_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dpStatus_t  stat,
  input  logic       ocFlag,
  input  logic       faultReq,
  output ctlStrobe_t ctl,
  output logic       gateOn
);
  logic lockQ;
  logic gateQ;
  logic setReq;
  logic clrReq;

  always_comb begin
    setReq = ~stat.limitZero & (lockQ ? stat.startOk : stat.wrap);
    clrReq = faultReq | ocFlag | stat.stopOk | (gateQ & stat.onDone);
    ctl.cntRestart = faultReq | (lockQ & stat.startOk);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gateQ <= 1'b0;
      lockQ <= 1'b0;
    end else begin
      // reset-dominant latch
      if (clrReq)      gateQ <= 1'b0;
      else if (setReq) gateQ <= 1'b1;
      if (faultReq)         lockQ <= 1'b0;
      else if (stat.stopOk) lockQ <= 1'b1;
    end
  end

  assign gateOn = gateQ;

endmodule

// File: rtl/pwm_handoff.sv
module pwm_handoff
  import pwmho_pkg::*;
#(
  parameter int PERIOD_CYC = 100,
  parameter int DUTY_PCT   = 72,
  parameter int MIN_W      = 6,
  parameter int MAX_W      = 50,
  localparam int PHASE_W   = $clog2(PERIOD_CYC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startEdge,
  input  logic               stopEdge,
  input  logic               ocFlag,
  input  logic               faultReq,
  input  logic [PHASE_W-1:0] ssLimit,
  output logic               gateOn
);
  ctlStrobe_t ctl;
  dpStatus_t  stat;

  pwmho_datapath #(
    .PERIOD_CYC(PERIOD_CYC),
    .DUTY_PCT  (DUTY_PCT),
    .MIN_W     (MIN_W),
    .MAX_W     (MAX_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .startIn(startEdge),
    .stopIn (stopEdge),
    .ssLimit(ssLimit),
    .ctl    (ctl),
    .stat   (stat)
  );

  pwmho_control u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat    (stat),
    .ocFlag  (ocFlag),
    .faultReq(faultReq),
    .ctl     (ctl),
    .gateOn  (gateOn)
  );

endmodule

// File: rtl/pwm_handoff_checker.sv
module pwm_handoff_checker
  import pwmho_pkg::*;
#(
  parameter int PERIOD_CYC = 100,
  parameter int DUTY_PCT   = 72,
  localparam int PHASE_W   = $clog2(PERIOD_CYC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gateOn,
  input logic               ocFlag,
  input logic               faultReq,
  input logic [PHASE_W-1:0] ssLimit,
  input dpStatus_t          stat
);
  localparam int MAX_ON = PERIOD_CYC * DUTY_PCT / 100;

  logic [15:0] hiRun;

  always_ff @(posedge clk) begin
    if (!rst_n)      hiRun <= '0;
    else if (gateOn) hiRun <= (hiRun == 16'hFFFF) ? hiRun : hiRun + 1'b1;
    else             hiRun <= '0;
  end

  AST_FAULT_CLEARS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    faultReq |=> !gateOn); // R10

  AST_OC_CLEARS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ocFlag |=> !gateOn); // R9

  AST_ON_TIME_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    gateOn |-> (hiRun < 16'(MAX_ON))); // R8

  AST_ZERO_LIMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateOn) |-> ($past(ssLimit) != '0)); // R3

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateOn) |-> $past(stat.startOk | stat.wrap)); // R7

endmodule

bind pwm_handoff pwm_handoff_checker #(
  .PERIOD_CYC(PERIOD_CYC),
  .DUTY_PCT  (DUTY_PCT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gateOn  (gateOn),
  .ocFlag  (ocFlag),
  .faultReq(faultReq),
  .ssLimit (ssLimit),
  .stat    (stat)
);

// File: tb/test_pwm_handoff.sv
`timescale 1ns/1ps
module test_pwm_handoff;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startEdge = 1'b0;
  logic       stopEdge = 1'b0;
  logic       ocFlag = 1'b0;
  logic       faultReq = 1'b0;
  logic [6:0] ssLimit = 7'd72;
  logic       gateOn;

  int checks = 0;
  int failures = 0;

  // bit7 = expected acceptance, bits 6:0 = stop pulse width in cycles
  localparam logic [7:0] STOP_VEC [6] = '{
    {1'b0, 7'd3}, {1'b0, 7'd5}, {1'b1, 7'd6},
    {1'b1, 7'd25}, {1'b1, 7'd50}, {1'b0, 7'd51}
  };

  always #2 clk = ~clk;

  pwm_handoff i_pwm_handoff (
    .clk(clk), .rst_n(rst_n), .startEdge(startEdge), .stopEdge(stopEdge),
    .ocFlag(ocFlag), .faultReq(faultReq), .ssLimit(ssLimit), .gateOn(gateOn)
  );

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s gateOn actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPulse(bit isStop, int w);
    if (isStop) stopEdge = 1'b1; else startEdge = 1'b1;
    tick(w);
    stopEdge = 1'b0;
    startEdge = 1'b0;
  endtask

  task automatic waitLevel(string req, logic lvl, int lim);
    for (int i = 0; i < lim; i++) begin
      if (gateOn === lvl) return;
      @(negedge clk);
    end
    checkBit(req, gateOn, lvl);
  endtask

  task automatic countHigh(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (gateOn === 1'b1) c++;
      @(negedge clk);
    end
  endtask

  task automatic dutyCheck(string req, int lim, int exp);
    int c;
    waitLevel(req, 1'b0, 200);
    ssLimit = 7'(lim);
    waitLevel(req, 1'b1, 200);
    countHigh(100, c);
    checkInt(req, c, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c;
    // R1 reset state and first local turn-on
    tick(5);
    checkBit("R1 in reset", gateOn, 1'b0);
    rst_n = 1'b1;
    tick(99);
    checkBit("R1 before first cycle", gateOn, 1'b0);
    tick(1);
    checkBit("R1 first cycle start", gateOn, 1'b1);
    countHigh(100, c);
    checkInt("R2 on-time at limit 72", c, 72);

    // R2 duty under several limits
    dutyCheck("R2 clamp of limit 90", 90, 72);
    dutyCheck("R2 limit 10", 10, 10);
    dutyCheck("R2 limit 1", 1, 1);

    // R3 zero limit
    waitLevel("R3", 1'b0, 200);
    ssLimit = 7'd0;
    countHigh(250, c);
    checkInt("R3 zero limit high count", c, 0);
    ssLimit = 7'd60;

    // R5 start before lock ignored (sent in the off window)
    waitLevel("R5", 1'b1, 200);
    waitLevel("R5", 1'b0, 200);
    sendPulse(1'b0, 10);
    tick(3);
    checkBit("R5 start before lock", gateOn, 1'b0);

    // R4 short stop before lock ignored, local control continues
    waitLevel("R4", 1'b1, 200);
    sendPulse(1'b1, 3);
    tick(3);
    checkBit("R4 short stop keeps gate", gateOn, 1'b1);
    waitLevel("R4", 1'b0, 200);
    waitLevel("R4 still local", 1'b1, 200);
    checkBit("R4 still local", gateOn, 1'b1);

    // R6 first valid stop clears and locks
    sendPulse(1'b1, 10);
    tick(2);
    checkBit("R7 stop latency two edges", gateOn, 1'b1);
    tick(1);
    checkBit("R6 first stop clears", gateOn, 1'b0);
    countHigh(250, c);
    checkInt("R6 no local set after lock", c, 0);

    // R4 / R7 stop width table in locked mode
    foreach (STOP_VEC[k]) begin
      sendPulse(1'b0, 10);
      tick(3);
      checkBit("R7 remote start sets", gateOn, 1'b1);
      sendPulse(1'b1, int'(STOP_VEC[k][6:0]));
      tick(3);
      checkBit("R4 stop width window", gateOn, ~STOP_VEC[k][7]);
      if (gateOn) sendPulse(1'b1, 10);
      waitLevel("R7 cleanup", 1'b0, 200);
    end

    // R4 short start in locked mode
    sendPulse(1'b0, 5);
    tick(3);
    checkBit("R4 short start ignored", gateOn, 1'b0);

    // R8 clamp while locked
    ssLimit = 7'd20;
    sendPulse(1'b0, 10);
    tick(3);
    countHigh(60, c);
    checkInt("R8 locked on-time clamp", c, 20);
    ssLimit = 7'd60;

    // R9 overcurrent ends pulse, lock kept
    sendPulse(1'b0, 10);
    tick(3);
    checkBit("R9 pre", gateOn, 1'b1);
    ocFlag = 1'b1;
    tick(1);
    ocFlag = 1'b0;
    checkBit("R9 overcurrent clears", gateOn, 1'b0);
    countHigh(150, c);
    checkInt("R9 lock kept no local set", c, 0);
    sendPulse(1'b0, 10);
    tick(3);
    checkBit("R9 remote start after oc", gateOn, 1'b1);

    // R10 fault clears gate and lock, local restarts
    faultReq = 1'b1;
    tick(1);
    checkBit("R10 fault clears", gateOn, 1'b0);
    tick(4);
    faultReq = 1'b0;
    tick(99);
    checkBit("R10 before local restart", gateOn, 1'b0);
    tick(1);
    checkBit("R10 local restart", gateOn, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule